// File: doc/BRIEF.md
# Reference-Gated Frequency Measurement Unit

This block measures how fast one of several candidate clocks runs compared with a trusted reference clock. Software uses one 32-bit control/status word. It picks a source, loads a reference-cycle budget and sets a start bit. The block then opens a counting window that lasts exactly that many reference cycles. During the window it counts rising edges of the selected clock in that clock's own domain.

Start and stop reach the measured domain through two-flop synchronizers. The frozen count returns to the reference domain through a toggle handshake. When the count arrives, the start bit clears itself. Software divides the returned count by the budget to get the frequency ratio. Synchronizer latency shifts both ends of the window by similar amounts, so the result is within a couple of counts of the true value. It can never be more precise than the reference itself.

The register interface runs on the reference clock. All domains share one asynchronous active-low reset.

Top module: `freq_meter`

## Requirements
- R1: After reset the status word reads all zeros: source code 0, start bit clear, both counts zero.
- R2: Word layout: source code in bits 31:24, start/busy bit at 23, measured count in bits 22:9, reference count in bits 8:0.
- R3: A write with bit 23 set while idle does four things: it loads the reference count from bits 8:0, latches the source code, clears the measured count and sets bit 23.
- R4: While counting, the reference count drops by one per reference cycle until it reaches zero.
- R5: When the measured count returns, bit 23 clears. The measured count is then within ±2 of max(N,1)·f_src/f_ref, where N is the loaded reference count.
- R6: Source codes 0 to 11 select `src_clk[code]` as the measured clock.
- R7: The measured count saturates at 3FFFh and does not wrap.
- R8: A source code above 11 selects no clock. The run still finishes after the reference budget, and the measured count reads zero.
- R9: While bit 23 is set, writes are ignored: the source code, the reference count and the run in progress are unaffected.
- R10: An idle write with bit 23 clear updates the source code and reference count. It starts nothing and leaves the measured count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; also clocks the register interface |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| src_clk | input | NSRC (12) | Candidate clocks to measure |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | REG_W (32) | Write data |
| rd_data | output | REG_W (32) | Current status word |

## Verification
If a synchronizer or toggle is out of step, the next run shows it at the ports. Either bit 23 never clears, or the returned count lands far outside the ±2 band. Both show within one measurement of the fault. A wrong reference-counter step shows in the readback one cycle after the start write. A broken source mux gives the wrong ratio on the first source whose period differs. A stale handshake after a no-source run corrupts the following valid run.

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter #(
  parameter int NSRC   = 12,
  parameter int SEL_W  = 8,
  parameter int FCNT_W = 14,
  parameter int RCNT_W = 9,
  parameter int REG_W  = SEL_W + 1 + FCNT_W + RCNT_W
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data
);
  localparam int GO_BIT = RCNT_W + FCNT_W;
  localparam int SEL_LO = GO_BIT + 1;
  localparam logic [FCNT_W-1:0] FMAX = {FCNT_W{1'b1}};

  logic [SEL_W-1:0]  sel_q;
  logic              busy_q, counting_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic [FCNT_W-1:0] fcnt_q;
  logic              go_t, stop_t;
  logic [2:0]        dn_s;

  logic [FCNT_W-1:0] mcnt_q;
  logic              run_q, done_t;
  logic [2:0]        gs, ss;
  logic              mclk;

  wire [SEL_W-1:0]  wr_sel = wr_data[SEL_LO +: SEL_W];
  wire              wr_go  = wr_data[GO_BIT];
  wire [RCNT_W-1:0] wr_rc  = wr_data[0 +: RCNT_W];
  wire sel_ok    = (32'(sel_q) < NSRC);
  wire wr_sel_ok = (32'(wr_sel) < NSRC);
  wire dn_p      = dn_s[2] ^ dn_s[1];
  wire go_p      = gs[2] ^ gs[1];
  wire stop_p    = ss[2] ^ ss[1];

  assign rd_data = {sel_q, busy_q, fcnt_q, rcnt_q};

  always_comb begin
    mclk = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (32'(sel_q) == i) mclk = src_clk[i];
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      busy_q     <= 1'b0;
      counting_q <= 1'b0;
      rcnt_q     <= '0;
      fcnt_q     <= '0;
      go_t       <= 1'b0;
      stop_t     <= 1'b0;
      dn_s       <= '0;
    end else begin
      dn_s <= {dn_s[1:0], done_t};
      if (wr_en && !busy_q) begin
        sel_q  <= wr_sel;
        rcnt_q <= wr_rc;
        if (wr_go) begin
          busy_q     <= 1'b1;
          counting_q <= 1'b1;
          fcnt_q     <= '0;
          if (wr_sel_ok) go_t <= ~go_t;
        end
      end else if (counting_q) begin
        if (rcnt_q <= RCNT_W'(1)) begin
          rcnt_q     <= '0;
          counting_q <= 1'b0;
          if (sel_ok) stop_t <= ~stop_t;
          else        busy_q <= 1'b0;
        end else begin
          rcnt_q <= rcnt_q - RCNT_W'(1);
        end
      end else if (busy_q && dn_p) begin
        fcnt_q <= mcnt_q;
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      gs     <= '0;
      ss     <= '0;
      mcnt_q <= '0;
      run_q  <= 1'b0;
      done_t <= 1'b0;
    end else begin
      gs <= {gs[1:0], go_t};
      ss <= {ss[1:0], stop_t};
      if (go_p)                        mcnt_q <= '0;
      else if (run_q && mcnt_q != FMAX) mcnt_q <= mcnt_q + FCNT_W'(1);
      if (stop_p) begin
        run_q  <= 1'b0;
        done_t <= ~done_t;
      end else if (go_p) begin
        run_q <= 1'b1;
      end
    end
  end

  p_start_load_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (wr_en && !busy_q && wr_data[GO_BIT]) |=> (busy_q && rcnt_q == $past(wr_data[0 +: RCNT_W]) && fcnt_q == '0));
  p_ref_step_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (counting_q && rcnt_q > RCNT_W'(1)) |=> (rcnt_q == $past(rcnt_q) - RCNT_W'(1)));
  p_done_clear_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (busy_q && !counting_q && dn_p) |=> (!rd_data[GO_BIT]));
  p_sat_hold_r7: assert property (@(posedge mclk) disable iff (!rst_n)
    (mcnt_q == FMAX && !go_p) |=> (mcnt_q == FMAX));
  p_nosrc_zero_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (busy_q && !sel_ok) |-> (fcnt_q == '0));
  p_busy_ignore_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> $stable(sel_q));
endmodule

// File: tb/sim_freq_meter.sv
`timescale 1ns/1ps
module sim_freq_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [11:0] srcs;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  function automatic real per(int i);
    case (i)
      0: return 10.0;  1: return 40.0;  2: return 4.0;   3: return 8.0;
      4: return 5.0;   5: return 20.0;  6: return 2.0;   7: return 1.0;
      8: return 25.0;  9: return 50.0;  10: return 16.0; default: return 0.4;
    endcase
  endfunction

  for (genvar g = 0; g < 12; g++) begin : gclk
    logic c = 1'b0;
    initial forever #(per(g) / 2.0) c = ~c;
    assign srcs[g] = c;
  end

  freq_meter u0 (.ref_clk(clk), .rst_n(rst_n), .src_clk(srcs),
                 .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  wire [7:0]  f_sel  = rd_data[31:24];
  wire        f_go   = rd_data[23];
  wire [13:0] f_fcnt = rd_data[22:9];
  wire [8:0]  f_rcnt = rd_data[8:0];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic measure(input int sel, input int n, output int got, output int cyc);
    wr({sel[7:0], 1'b0, 14'd0, n[8:0]});
    wr({sel[7:0], 1'b1, 14'd0, n[8:0]});
    chk(f_go == 1'b1, "R3 start bit", f_go, 1);
    chk(f_rcnt == n[8:0], "R3 rcnt load", f_rcnt, n);
    chk(f_fcnt == 0, "R3 fcnt clear", f_fcnt, 0);
    chk(f_sel == sel[7:0], "R2 sel field", f_sel, sel);
    cyc = 0;
    @(negedge clk); cyc++;
    if (n > 1) chk(f_rcnt == n[8:0] - 9'd1, "R4 ref decrement", f_rcnt, n - 1);
    while (f_go && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(!f_go, "R5 start bit self-clears", f_go, 0);
    got = f_fcnt;
  endtask

  function automatic int expect_cnt(int sel, int n);
    real e;
    e = ((n < 1) ? 1 : n) * 20.0 / per(sel);
    if (e > 16383.0) e = 16383.0;
    return int'(e);
  endfunction

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int got, cyc, e, prev;
    int ns[3] = '{5, 37, 200};
    repeat (3) @(negedge clk);
    chk(rd_data == 32'd0, "R1 reset word", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 32'd0, "R1 idle after reset", rd_data, 0);

    for (int s = 0; s < 12; s++)
      for (int k = 0; k < 3; k++) begin
        measure(s, ns[k], got, cyc);
        e = expect_cnt(s, ns[k]);
        chk(got >= e - 2 && got <= e + 2, $sformatf("R5/R6 src %0d n %0d", s, ns[k]), got, e);
      end

    measure(6, 1, got, cyc);
    e = expect_cnt(6, 1);
    chk(got >= e - 2 && got <= e + 2, "R5 single-cycle window", got, e);
    measure(7, 511, got, cyc);
    e = expect_cnt(7, 511);
    chk(got >= e - 2 && got <= e + 2, "R5 full budget", got, e);

    measure(11, 511, got, cyc);
    chk(got == 16383, "R7 saturation", got, 16383);

    measure(12, 10, got, cyc);
    chk(got == 0, "R8 code 12 no source", got, 0);
    chk(cyc <= 12, "R8 finishes on budget", cyc, 12);
    measure(255, 40, got, cyc);
    chk(got == 0, "R8 code FFh no source", got, 0);
    measure(0, 50, got, cyc);
    e = expect_cnt(0, 50);
    chk(got >= e - 2 && got <= e + 2, "R8 valid run after no-source", got, e);

    wr({8'd2, 1'b1, 14'd0, 9'd300});
    repeat (3) @(negedge clk);
    wr({8'd5, 1'b1, 14'd0, 9'd7});
    chk(f_sel == 8'd2, "R9 sel unchanged while busy", f_sel, 2);
    chk(f_rcnt > 9'd280 && f_rcnt < 9'd300, "R9 rcnt keeps counting", f_rcnt, 295);
    cyc = 0;
    while (f_go && cyc < 5000) begin @(negedge clk); cyc++; end
    e = expect_cnt(2, 300);
    chk(f_fcnt >= 14'(e - 2) && f_fcnt <= 14'(e + 2), "R9 run unaffected", f_fcnt, e);
    prev = f_fcnt;

    wr({8'd3, 1'b0, 14'd0, 9'd77});
    chk(f_sel == 8'd3, "R10 sel updated", f_sel, 3);
    chk(f_rcnt == 9'd77, "R10 rcnt updated", f_rcnt, 77);
    chk(f_fcnt == 14'(prev), "R10 fcnt retained", f_fcnt, prev);
    repeat (20) @(negedge clk);
    chk(!f_go && f_rcnt == 9'd77, "R10 no run started", f_rcnt, 77);

    summary();
  end
endmodule